// File: doc/BRIEF.md
# Disk Sector Receive Buffer

This block sits between a drive's serial read path and the rest of a controller. It watches a qualified bit stream for a fixed synchronisation pattern. It then collects the data field of one sector into an on-chip buffer, packing the bits into bytes. At the same time it runs a CRC over those data bits, and afterwards compares it with the 16-bit check code that follows the data.

Only a sector whose check code matches is released to the read side. The reader pulls the bytes through a ready/valid port at any pace it likes, while the drive side keeps streaming. A failed check leaves a sticky error flag and discards the sector. A sync pattern that arrives while a good sector is still waiting to be read is ignored and leaves a sticky overrun flag. The single buffer is therefore never overwritten before it has been drained.

Top module: `sector_rx_buf`

## Requirements
- R1: After reset, sector_ready, rd_valid, crc_error and overrun are all 0.
- R2: A bit is taken only on a clock edge where bit_valid is 1; bit_in is ignored otherwise. Reception starts when the last 16 accepted bits, oldest first, equal 0xA1A1 exactly. A pattern that differs in any bit (for example 0xA1A0) starts nothing.
- R3: The 4096 bits that follow the sync pattern form 512 data bytes. The first bit of each byte is its MSB, and the first byte received is read out first.
- R4: The 16-bit check code follows the data, MSB first. The CRC uses polynomial 0x1021 and initial value 0xFFFF, and processes the data bits in stream order, MSB of each byte first. On a match, sector_ready goes to 1 two clock edges after the edge that accepted the last check-code bit.
- R5: On a mismatch, crc_error goes to 1 one clock edge after the edge that accepted the last check-code bit. It stays 1 until reset, and sector_ready stays 0 for that sector.
- R6: rd_valid equals sector_ready. While it is 1, rd_data shows the byte at the current read index. The index advances on each edge where rd_valid and rd_ready are both 1. With rd_ready at 0, rd_data holds its value.
- R7: sector_ready and rd_valid fall on the edge that completes the 512th read handshake, and stay at 1 until then.
- R8: A full sync pattern accepted while sector_ready is 1 starts no reception. overrun goes to 1 one edge after the edge that accepted its last bit, and stays 1 until reset. The held sector's bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Qualifies bit_in on this edge |
| bit_in | input | 1 | Serial bit from the drive |
| rd_ready | input | 1 | Reader accepts the byte shown |
| rd_valid | output | 1 | A byte of a good sector is shown |
| rd_data | output | 8 | Byte at the current read index |
| sector_ready | output | 1 | A verified sector waits in the buffer |
| crc_error | output | 1 | Sticky: a sector failed its check |
| overrun | output | 1 | Sticky: sync seen while a sector was held |

## Verification
Each flag has its own latency from the edge that accepts the bit deciding it:
- crc_error and overrun are due one edge after that bit.
- sector_ready is due one edge later than crc_error and overrun.
- A read handshake shows its effect on the next edge.

The bench drives inputs on the falling edge and samples there. For each flag it waits exactly the stated number of falling edges after the deciding bit. It checks that sector_ready is still 0 one edge early and is 1 on the due edge. Bytes and stalls are checked on the falling edge just before the rising edge that would complete the handshake.

// File: rtl/sector_rx_buf_pkg.sv
package sector_rx_buf_pkg;

    localparam int CRC_W = 16;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_DATA,
        RX_CODE
    } rx_state_e;

    // One serial CRC step, MSB-first register, feedback from the top bit.
    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] crc,
        input logic             bit_v,
        input logic [CRC_W-1:0] poly
    );
        logic [CRC_W-1:0] shifted;
        shifted = {crc[CRC_W-2:0], 1'b0};
        return (crc[CRC_W-1] ^ bit_v) ? (shifted ^ poly) : shifted;
    endfunction

endpackage

// File: rtl/sector_rx_framer.sv
module sector_rx_framer
    import sector_rx_buf_pkg::*;
#(
    parameter int                     DATA_BYTES = 512,
    parameter int                     SYNC_W     = 16,
    parameter logic [SYNC_W-1:0]      SYNC_WORD  = 16'hA1A1,
    parameter logic [CRC_W-1:0]       CRC_POLY   = 16'h1021,
    parameter logic [CRC_W-1:0]       CRC_INIT   = 16'hFFFF,
    localparam int                    ADDR_W     = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              held,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              good_pulse,
    output logic              err_flag,
    output logic              ovr_flag
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DATA_BYTES - 1);
    localparam logic [ADDR_W-1:0] ONE_IDX  = ADDR_W'(1);
    localparam int                CNT_W    = $clog2(CRC_W);
    localparam logic [CNT_W-1:0]  CODE_END = CNT_W'(CRC_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [SYNC_W-1:0] sync_sh;
        logic [6:0]        byte_sh;
        logic [2:0]        bit_cnt;
        logic [ADDR_W-1:0] byte_idx;
        logic [CRC_W-1:0]  crc;
        logic [CRC_W-1:0]  code;
        logic [CNT_W-1:0]  code_cnt;
        logic              good;
        logic              err;
        logic              ovr;
    } rx_t;

    rx_t rx_d, rx_q;

    logic [SYNC_W-1:0] sync_next;
    logic [CRC_W-1:0]  code_next;

    always_comb begin
        rx_d      = rx_q;
        rx_d.good = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = rx_q.byte_idx;
        wr_data   = {rx_q.byte_sh, bit_in};
        sync_next = {rx_q.sync_sh[SYNC_W-2:0], bit_in};
        code_next = {rx_q.code[CRC_W-2:0], bit_in};

        if (bit_valid) begin
            unique case (rx_q.state)
                RX_HUNT: begin
                    rx_d.sync_sh = sync_next;
                    if (sync_next == SYNC_WORD) begin
                        rx_d.sync_sh = '0;
                        if (held) begin
                            rx_d.ovr = 1'b1;
                        end else begin
                            rx_d.state    = RX_DATA;
                            rx_d.crc      = CRC_INIT;
                            rx_d.bit_cnt  = '0;
                            rx_d.byte_idx = '0;
                        end
                    end
                end
                RX_DATA: begin
                    rx_d.crc     = crc_step(rx_q.crc, bit_in, CRC_POLY);
                    rx_d.byte_sh = {rx_q.byte_sh[5:0], bit_in};
                    rx_d.bit_cnt = rx_q.bit_cnt + 3'd1;
                    if (rx_q.bit_cnt == 3'd7) begin
                        wr_en         = 1'b1;
                        rx_d.byte_idx = rx_q.byte_idx + ONE_IDX;
                        if (rx_q.byte_idx == LAST_IDX) begin
                            rx_d.state    = RX_CODE;
                            rx_d.code_cnt = '0;
                        end
                    end
                end
                RX_CODE: begin
                    rx_d.code     = code_next;
                    rx_d.code_cnt = rx_q.code_cnt + CNT_W'(1);
                    if (rx_q.code_cnt == CODE_END) begin
                        if (code_next == rx_q.crc) begin
                            rx_d.good = 1'b1;
                        end else begin
                            rx_d.err = 1'b1;
                        end
                        rx_d.state   = RX_HUNT;
                        rx_d.sync_sh = '0;
                    end
                end
                default: rx_d.state = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q       <= '0;
            rx_q.state <= RX_HUNT;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign good_pulse = rx_q.good;
    assign err_flag   = rx_q.err;
    assign ovr_flag   = rx_q.ovr;

endmodule

// File: rtl/sector_rx_ram.sv
module sector_rx_ram #(
    parameter int  DATA_BYTES = 512,
    parameter int  BYTE_W     = 8,
    localparam int ADDR_W     = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] mem_q [DATA_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/sector_rx_reader.sv
module sector_rx_reader #(
    parameter int  DATA_BYTES = 512,
    localparam int ADDR_W     = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_ready,
    input  logic              rd_ready,
    output logic              held,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DATA_BYTES - 1);
    localparam logic [ADDR_W-1:0] ONE_IDX  = ADDR_W'(1);

    typedef struct packed {
        logic              ready;
        logic [ADDR_W-1:0] addr;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_q.ready && rd_ready) begin
            if (rd_q.addr == LAST_IDX) begin
                rd_d.ready = 1'b0;
                rd_d.addr  = '0;
            end else begin
                rd_d.addr = rd_q.addr + ONE_IDX;
            end
        end
        if (set_ready) begin
            rd_d.ready = 1'b1;
            rd_d.addr  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign held    = rd_q.ready;
    assign rd_addr = rd_q.addr;

endmodule

// File: rtl/sector_rx_buf.sv
module sector_rx_buf
    import sector_rx_buf_pkg::*;
#(
    parameter int  DATA_BYTES = 512,
    localparam int ADDR_W     = $clog2(DATA_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       rd_ready,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       sector_ready,
    output logic       crc_error,
    output logic       overrun
);

    logic              held;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              good_pulse;

    sector_rx_framer #(
        .DATA_BYTES (DATA_BYTES)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .held       (held),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .good_pulse (good_pulse),
        .err_flag   (crc_error),
        .ovr_flag   (overrun)
    );

    sector_rx_ram #(
        .DATA_BYTES (DATA_BYTES),
        .BYTE_W     (8)
    ) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    sector_rx_reader #(
        .DATA_BYTES (DATA_BYTES)
    ) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ready (good_pulse),
        .rd_ready  (rd_ready),
        .held      (held),
        .rd_addr   (rd_addr)
    );

    assign sector_ready = held;
    assign rd_valid     = held;

endmodule

// File: rtl/sector_rx_buf_chk.sv
module sector_rx_buf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_ready,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       sector_ready,
    input logic       crc_error,
    input logic       overrun
);

    assert_valid_matches_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == sector_ready);

    assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_ready && !rd_ready) |=> sector_ready);

    assert_crc_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |=> crc_error);

    assert_error_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_error) |-> !sector_ready);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_overrun_while_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(sector_ready));

endmodule

bind sector_rx_buf sector_rx_buf_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_ready     (rd_ready),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .sector_ready (sector_ready),
    .crc_error    (crc_error),
    .overrun      (overrun)
);

// File: tb/sector_rx_buf_tb.sv
module sector_rx_buf_tb;

    localparam int NB = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       rd_ready = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       sector_ready;
    logic       crc_error;
    logic       overrun;

    int checks = 0;
    int failures = 0;
    bit gaps_en = 1'b1;
    int unsigned seed_dummy;

    logic [7:0] sec_buf  [NB];
    logic [7:0] keep_buf [NB];

    always #4 clk = ~clk;

    sector_rx_buf u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_valid    (bit_valid),
        .bit_in       (bit_in),
        .rd_ready     (rd_ready),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .sector_ready (sector_ready),
        .crc_error    (crc_error),
        .overrun      (overrun)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic logic [15:0] ref_crc(input bit use_keep);
        logic [15:0] c = 16'hFFFF;
        logic [7:0]  b;
        for (int i = 0; i < NB; i++) begin
            b = use_keep ? keep_buf[i] : sec_buf[i];
            for (int k = 7; k >= 0; k--) begin
                if (c[15] ^ b[k]) c = {c[14:0], 1'b0} ^ 16'h1021;
                else              c = {c[14:0], 1'b0};
            end
        end
        return c;
    endfunction

    task automatic send_bit(input logic b);
        if (gaps_en && ($urandom % 4 == 0)) begin
            @(negedge clk);
            bit_valid = 1'b0;
            bit_in    = 1'($urandom);
        end
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        @(posedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) send_bit(b[k]);
    endtask

    task automatic go_idle();
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in    = 1'($urandom);
    endtask

    task automatic fill_random();
        for (int i = 0; i < NB; i++) sec_buf[i] = 8'($urandom);
    endtask

    // Sends sync, data from sec_buf and a code; leaves the bench at the
    // negedge right after the edge that accepted the last code bit.
    task automatic send_sector(input bit corrupt, input bit probe_ovr);
        logic [15:0] code;
        code = ref_crc(1'b0) ^ (corrupt ? 16'h0100 : 16'h0000);
        send_byte(8'hA1);
        send_byte(8'hA1);
        if (probe_ovr) begin
            go_idle();
            check(overrun == 1'b1, "R8 overrun one edge after sync while held", int'(overrun), 1);
        end
        for (int i = 0; i < NB; i++) send_byte(sec_buf[i]);
        send_byte(code[15:8]);
        send_byte(code[7:0]);
        go_idle();
    endtask

    task automatic read_sector(input bit use_keep, input string tag);
        int   idx = 0;
        int   bad = 0;
        int   stall_bad = 0;
        int   guard = 0;
        bit   prev_stall = 1'b0;
        logic [7:0] prev_data = '0;
        logic [7:0] exp_b;
        while (idx < NB && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (prev_stall && rd_data != prev_data) stall_bad++;
            rd_ready = ($urandom % 3 != 0);
            if (rd_valid) begin
                exp_b = use_keep ? keep_buf[idx] : sec_buf[idx];
                if (rd_ready) begin
                    if (rd_data != exp_b) begin
                        if (bad == 0)
                            $display("FAIL R3 %s byte %0d actual=%0d expected=%0d", tag, idx, rd_data, exp_b);
                        bad++;
                    end
                    idx++;
                    prev_stall = 1'b0;
                end else begin
                    prev_stall = 1'b1;
                    prev_data  = rd_data;
                end
            end else begin
                if (idx < NB) bad++;
                idx = NB;
            end
        end
        checks++;
        if (bad != 0) failures++;
        check(stall_bad == 0, "R6 rd_data stable while stalled", stall_bad, 0);
        check(idx == NB && guard < 20000, "R6 all bytes delivered", idx, NB);
        @(negedge clk);
        rd_ready = 1'b0;
        check(sector_ready == 1'b0 && rd_valid == 1'b0, "R7 ready drops after last byte",
              int'(sector_ready), 0);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5EC7_0001);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sector_ready && !rd_valid && !crc_error && !overrun, "R1 reset state",
              int'({sector_ready, rd_valid, crc_error, overrun}), 0);

        // Sector A: random data, random bit_valid gaps with random bit_in.
        repeat (20) send_bit(1'b0);
        fill_random();
        send_sector(1'b0, 1'b0);
        check(sector_ready == 1'b0, "R4 ready not yet one edge after code", int'(sector_ready), 0);
        @(negedge clk);
        check(sector_ready == 1'b1, "R4 ready two edges after code", int'(sector_ready), 1);
        check(rd_valid == 1'b1, "R6 rd_valid follows ready", int'(rd_valid), 1);
        check(crc_error == 1'b0, "R4 no error on good sector", int'(crc_error), 0);
        read_sector(1'b0, "sector A");

        // Near-miss sync followed by zeros: nothing may start.
        send_byte(8'hA1);
        send_byte(8'hA0);
        repeat (4200) send_bit(1'b0);
        go_idle();
        repeat (3) @(negedge clk);
        check(sector_ready == 1'b0 && crc_error == 1'b0, "R2 near-miss sync ignored",
              int'({sector_ready, crc_error}), 0);

        // Sector B held, sector C arrives while held.
        fill_random();
        send_sector(1'b0, 1'b0);
        @(negedge clk);
        check(sector_ready == 1'b1, "R4 second sector ready", int'(sector_ready), 1);
        check(overrun == 1'b0, "R8 no overrun yet", int'(overrun), 0);
        for (int i = 0; i < NB; i++) keep_buf[i] = sec_buf[i];
        fill_random();
        send_sector(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check(overrun == 1'b1 && crc_error == 1'b0, "R8 overrun sticky, no error",
              int'({overrun, crc_error}), 2);
        read_sector(1'b1, "held sector B");

        // Bad check code.
        fill_random();
        send_sector(1'b1, 1'b0);
        check(crc_error == 1'b1, "R5 error one edge after code", int'(crc_error), 1);
        repeat (5) @(negedge clk);
        check(sector_ready == 1'b0 && rd_valid == 1'b0, "R5 bad sector not offered",
              int'(sector_ready), 0);

        // Good sector without gaps after an error; error stays.
        gaps_en = 1'b0;
        fill_random();
        send_sector(1'b0, 1'b0);
        @(negedge clk);
        check(sector_ready == 1'b1, "R4 good sector after error", int'(sector_ready), 1);
        check(crc_error == 1'b1, "R5 error sticky", int'(crc_error), 1);
        read_sector(1'b0, "sector D");
        check(overrun == 1'b1, "R8 overrun stays set", int'(overrun), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule